// File: doc/BRIEF.md
# Microcontroller Clock Source Selection Unit

This unit produces the system clock and the instruction-clock enable for a small microcontroller core. Three free-running clocks arrive at its inputs: an on-chip ring oscillator, a main clock and a sub clock. Out of reset the core always runs from the ring oscillator. A one-shot strobe from the core's instruction decoder then records whether the main clock comes from a ceramic resonator or an RC network. After that, a mode input picks main or sub as the source and one of four power-of-two divide ratios for the system clock.

Source changes are glitch-free. The source in use is gated off on its own falling edge before the new source is enabled on its own falling edge. A fixed divide-by-3 stage turns the system clock into a one-cycle instruction enable. A stabilisation counter holds off a one-cycle program-start pulse after reset and after any wakeup from power-down, whether the wakeup comes from a key or from a timer.

All control inputs (the strobes and `mode_i`) are synchronous to the ring oscillator clock. The wake inputs are synchronised inside the unit.

Top module: `mcu_clk_unit`

## Requirements
- R1: While reset is asserted and after it is released, `src_o` reads 2'b00 (ring oscillator) and the system clock follows the ring oscillator. Before a main-clock type has been latched, `mode_i[0]` has no effect on the source.
- R2: A `cer_sel_i` strobe sampled on a ring clock edge latches the ceramic type, and `src_o` reads 2'b01 after that edge. A `rc_sel_i` strobe latches the RC type, and `src_o` reads 2'b10. If both strobes arrive in the same cycle, ceramic wins.
- R3: Once a type is latched, later strobes of either kind change nothing until the next reset, and `src_o` never returns to 2'b00.
- R4: With a type latched, `mode_i[0]`=0 selects the main clock, and `src_o` shows that type. `mode_i[0]`=1 selects the sub clock, and `src_o` reads 2'b11.
- R5: `mode_i[2:1]` sets the system clock period to the selected source period times 1 (00), 2 (01), 4 (10) or 8 (11).
- R6: At no time is more than one source clock enabled onto the internal source clock.
- R7: `inst_en_o` is high for exactly one system clock cycle in every three. After reset it is first high after the second system clock rising edge, then every third edge after that.
- R8: After reset release, `prog_start_o` is high for exactly one source clock cycle, following the WAIT_CYC-th source rising edge.
- R9: A rising level on `key_wake_i` or on `tmr_wake_i` restarts the wait. `prog_start_o` then rises after the (WAIT_CYC+3)-th source rising edge, counting the first edge at which the wake input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ring_i | input | 1 | On-chip ring oscillator clock, also the control clock |
| clk_main_i | input | 1 | Main clock (ceramic or RC) |
| clk_sub_i | input | 1 | Sub clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cer_sel_i | input | 1 | Strobe: main clock is a ceramic resonator |
| rc_sel_i | input | 1 | Strobe: main clock is an RC oscillator |
| mode_i | input | 3 | [0] sub select, [2:1] divide ratio |
| key_wake_i | input | 1 | Key wakeup from power-down |
| tmr_wake_i | input | 1 | Timer wakeup from power-down |
| sys_clk_o | output | 1 | System clock |
| inst_en_o | output | 1 | Instruction clock enable, one pulse per three system cycles |
| src_o | output | 2 | Selected source code |
| prog_start_o | output | 1 | One-cycle program start pulse |

## Verification
`src_o` settles in the ring cycle in which a strobe or mode change is registered, so the bench samples it at the next ring falling edge. `prog_start_o` is due WAIT_CYC ring edges after reset release and WAIT_CYC+3 edges after a wake input rises. The bench counts ring rising edges and samples at each falling edge to find the exact edge of the pulse. Period results are taken only after 30 ring cycles and four system edges have let the synchronisers and the divider settle. Each period is then measured as the time between consecutive system clock rising edges, and the instruction pulses are counted over nine system cycles.

// File: rtl/mcu_clk_pkg.sv
package mcu_clk_pkg;
  localparam int NSRC     = 3;
  localparam int IDX_RING = 0;
  localparam int IDX_MAIN = 1;
  localparam int IDX_SUB  = 2;

  typedef enum logic [1:0] {
    SRC_RING     = 2'b00,
    SRC_MAIN_CER = 2'b01,
    SRC_MAIN_RC  = 2'b10,
    SRC_SUB      = 2'b11
  } src_code_e;
endpackage

// File: rtl/mcu_clk_sel_ctl.sv
module mcu_clk_sel_ctl
  import mcu_clk_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cer_sel_i,
  input  logic            rc_sel_i,
  input  logic            sub_sel_i,
  output logic [NSRC-1:0] want_o,
  output logic [1:0]      code_o
);
  logic cer_q, rc_q, main_on;

  assign main_on = cer_q | rc_q;

  // first strobe wins, latched until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cer_q <= 1'b0;
      rc_q  <= 1'b0;
    end else if (!main_on) begin
      if (cer_sel_i)     cer_q <= 1'b1;
      else if (rc_sel_i) rc_q  <= 1'b1;
    end
  end

  always_comb begin
    want_o = '0;
    code_o = SRC_RING;
    if (!main_on) begin
      want_o[IDX_RING] = 1'b1;
    end else if (sub_sel_i) begin
      want_o[IDX_SUB] = 1'b1;
      code_o          = SRC_SUB;
    end else begin
      want_o[IDX_MAIN] = 1'b1;
      code_o           = cer_q ? SRC_MAIN_CER : SRC_MAIN_RC;
    end
  end
endmodule

// File: rtl/mcu_clk_glitchless_mux.sv
module mcu_clk_glitchless_mux #(
  parameter int N = 3
) (
  input  logic [N-1:0] clks_i,
  input  logic         rst_ni,
  input  logic [N-1:0] want_i,
  output logic [N-1:0] en_o,
  output logic         clk_o
);
  logic [N-1:0] en_q;
  logic [N-1:0] gated;

  for (genvar k = 0; k < N; k++) begin : g_src
    logic [N-1:0] mask;
    logic         req, s1_q, s2_q;
    assign mask = ~(N'(1) << k);
    // enable only once every other source has dropped
    assign req  = want_i[k] & ~|(en_q & mask);

    always_ff @(negedge clks_i[k] or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= (k == 0);
        s2_q <= (k == 0);
      end else begin
        s1_q <= req;
        s2_q <= s1_q;
      end
    end

    assign en_q[k]  = s2_q;
    assign gated[k] = clks_i[k] & s2_q;
  end

  assign en_o  = en_q;
  assign clk_o = |gated;
endmodule

// File: rtl/mcu_clk_div.sv
module mcu_clk_div #(
  parameter int RATIO_W  = 2,
  parameter int INST_DIV = 3
) (
  input  logic               src_clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               sys_clk_o,
  output logic               inst_en_o
);
  localparam int NTAP  = 1 << RATIO_W;
  localparam int CNT_W = NTAP - 1;
  localparam int IC_W  = $clog2(INST_DIV);

  logic [RATIO_W-1:0] r1_q, r2_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NTAP-1:0]    taps;
  logic [IC_W-1:0]    ic_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1_q  <= '0;
      r2_q  <= '0;
      cnt_q <= '0;
    end else begin
      r1_q  <= ratio_i;
      r2_q  <= r1_q;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign taps[0] = src_clk_i;
  for (genvar t = 1; t < NTAP; t++) begin : g_tap
    assign taps[t] = cnt_q[t-1];
  end

  assign sys_clk_o = taps[r2_q];

  always_ff @(posedge sys_clk_o or negedge rst_ni) begin
    if (!rst_ni)                               ic_q <= '0;
    else if (ic_q == IC_W'(INST_DIV - 1))      ic_q <= '0;
    else                                       ic_q <= ic_q + 1'b1;
  end

  assign inst_en_o = (ic_q == IC_W'(INST_DIV - 1));
endmodule

// File: rtl/mcu_clk_stab_wait.sv
module mcu_clk_stab_wait #(
  parameter int WAIT_CYC = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  output logic start_o
);
  localparam int CNT_W = $clog2(WAIT_CYC);

  logic             w1_q, w2_q, w3_q, rise;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w1_q <= 1'b0;
      w2_q <= 1'b0;
      w3_q <= 1'b0;
    end else begin
      w1_q <= wake_i;
      w2_q <= w1_q;
      w3_q <= w2_q;
    end
  end

  assign rise = w2_q & ~w3_q;

  // reset leaves the counter running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b1;
      start_q <= 1'b0;
    end else if (rise) begin
      cnt_q   <= '0;
      busy_q  <= 1'b1;
      start_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(WAIT_CYC - 1)) begin
        cnt_q   <= '0;
        busy_q  <= 1'b0;
        start_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        start_q <= 1'b0;
      end
    end else begin
      start_q <= 1'b0;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/mcu_clk_unit.sv
module mcu_clk_unit
  import mcu_clk_pkg::*;
#(
  parameter int WAIT_CYC = 16384,
  parameter int RATIO_W  = 2,
  parameter int INST_DIV = 3
) (
  input  logic               clk_ring_i,
  input  logic               clk_main_i,
  input  logic               clk_sub_i,
  input  logic               rst_ni,
  input  logic               cer_sel_i,
  input  logic               rc_sel_i,
  input  logic [RATIO_W:0]   mode_i,
  input  logic               key_wake_i,
  input  logic               tmr_wake_i,
  output logic               sys_clk_o,
  output logic               inst_en_o,
  output logic [1:0]         src_o,
  output logic               prog_start_o
);
  logic [NSRC-1:0] want;
  logic [NSRC-1:0] src_clks;
  logic [NSRC-1:0] src_en;
  logic            src_clk;

  assign src_clks[IDX_RING] = clk_ring_i;
  assign src_clks[IDX_MAIN] = clk_main_i;
  assign src_clks[IDX_SUB]  = clk_sub_i;

  mcu_clk_sel_ctl i_sel_ctl (
    .clk_i     (clk_ring_i),
    .rst_ni    (rst_ni),
    .cer_sel_i (cer_sel_i),
    .rc_sel_i  (rc_sel_i),
    .sub_sel_i (mode_i[0]),
    .want_o    (want),
    .code_o    (src_o)
  );

  mcu_clk_glitchless_mux #(.N(NSRC)) i_mux (
    .clks_i (src_clks),
    .rst_ni (rst_ni),
    .want_i (want),
    .en_o   (src_en),
    .clk_o  (src_clk)
  );

  mcu_clk_div #(.RATIO_W(RATIO_W), .INST_DIV(INST_DIV)) i_div (
    .src_clk_i (src_clk),
    .rst_ni    (rst_ni),
    .ratio_i   (mode_i[RATIO_W:1]),
    .sys_clk_o (sys_clk_o),
    .inst_en_o (inst_en_o)
  );

  mcu_clk_stab_wait #(.WAIT_CYC(WAIT_CYC)) i_wait (
    .clk_i   (src_clk),
    .rst_ni  (rst_ni),
    .wake_i  (key_wake_i | tmr_wake_i),
    .start_o (prog_start_o)
  );
endmodule

// File: rtl/mcu_clk_unit_chk.sv
module mcu_clk_unit_chk
  import mcu_clk_pkg::*;
(
  input logic            clk_ring_i,
  input logic            rst_ni,
  input logic [1:0]      src_o,
  input logic            sys_clk_o,
  input logic            inst_en_o,
  input logic            prog_start_o,
  input logic            src_clk,
  input logic [NSRC-1:0] src_en
);
  // R3
  src_sticky_chk: assert property (@(posedge clk_ring_i) disable iff (!rst_ni)
    (src_o != SRC_RING) |=> (src_o != SRC_RING));

  // R2
  cer_kept_chk: assert property (@(posedge clk_ring_i) disable iff (!rst_ni)
    (src_o == SRC_MAIN_CER) |=> (src_o != SRC_MAIN_RC));

  // R2
  rc_kept_chk: assert property (@(posedge clk_ring_i) disable iff (!rst_ni)
    (src_o == SRC_MAIN_RC) |=> (src_o != SRC_MAIN_CER));

  // R6
  one_src_chk: assert property (@(posedge clk_ring_i) disable iff (!rst_ni)
    $onehot0(src_en));

  // R7
  inst_single_chk: assert property (@(posedge sys_clk_o) disable iff (!rst_ni)
    inst_en_o |=> !inst_en_o);

  // R8
  start_single_chk: assert property (@(posedge src_clk) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o);
endmodule

bind mcu_clk_unit mcu_clk_unit_chk i_chk (
  .clk_ring_i   (clk_ring_i),
  .rst_ni       (rst_ni),
  .src_o        (src_o),
  .sys_clk_o    (sys_clk_o),
  .inst_en_o    (inst_en_o),
  .prog_start_o (prog_start_o),
  .src_clk      (src_clk),
  .src_en       (src_en)
);

// File: tb/test_mcu_clk_unit.sv
`timescale 1ns/1ps
module test_mcu_clk_unit;
  localparam int WAIT = 64;
  localparam int RING_PS = 20000;
  localparam int MAIN_PS = 14000;
  localparam int SUB_PS  = 60000;

  logic       clk_ring = 1'b0, clk_main = 1'b0, clk_sub = 1'b0;
  logic       rst_n = 1'b0, cer = 1'b0, rc = 1'b0, kw = 1'b0, tw = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       sys_clk, inst_en, pstart;
  logic [1:0] src;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  always #10 clk_ring = ~clk_ring;
  initial begin #3; forever #7  clk_main = ~clk_main; end
  initial begin #5; forever #30 clk_sub  = ~clk_sub;  end

  mcu_clk_unit #(.WAIT_CYC(WAIT)) i_mcu_clk_unit (
    .clk_ring_i (clk_ring), .clk_main_i (clk_main), .clk_sub_i (clk_sub),
    .rst_ni (rst_n), .cer_sel_i (cer), .rc_sel_i (rc), .mode_i (mode),
    .key_wake_i (kw), .tmr_wake_i (tw),
    .sys_clk_o (sys_clk), .inst_en_o (inst_en), .src_o (src), .prog_start_o (pstart)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_period(input logic [2:0] m, input bit latched);
    int base;
    base = (latched && m[0]) ? SUB_PS : (latched ? MAIN_PS : RING_PS);
    return base * (1 << m[2:1]);
  endfunction

  function automatic int exp_code(input logic [2:0] m, input int main_code);
    return m[0] ? 3 : main_code;
  endfunction

  task automatic do_reset();
    int seen_at, seen_n;
    mode = 3'b000; cer = 0; rc = 0; kw = 0; tw = 0;
    @(negedge clk_ring); rst_n = 0;
    repeat (3) @(negedge clk_ring);
    chk("R1", "src in reset", int'(src), 0);
    chk("R8", "start in reset", int'(pstart), 0);
    rst_n = 1;
    seen_at = 0; seen_n = 0;
    for (int n = 1; n <= WAIT + 3; n++) begin
      @(posedge clk_ring); @(negedge clk_ring);
      if (n <= 9) chk("R7", "inst_en after reset", int'(inst_en), int'(n % 3 == 2));
      if (pstart) begin seen_n++; if (seen_at == 0) seen_at = n; end
    end
    chk("R8", "start edge", seen_at, WAIT);
    chk("R8", "start pulses", seen_n, 1);
    chk("R1", "src after reset", int'(src), 0);
  endtask

  task automatic wake_test(input bit use_key);
    int seen_at, seen_n;
    seen_at = 0; seen_n = 0;
    @(negedge clk_ring);
    if (use_key) kw = 1; else tw = 1;
    for (int n = 1; n <= WAIT + 8; n++) begin
      @(posedge clk_ring); @(negedge clk_ring);
      if (n == 6) begin kw = 0; tw = 0; end
      if (pstart) begin seen_n++; if (seen_at == 0) seen_at = n; end
    end
    chk("R9", use_key ? "key wake start edge" : "timer wake start edge", seen_at, WAIT + 3);
    chk("R9", "wake start pulses", seen_n, 1);
  endtask

  task automatic measure(input string req, input int exp_ps);
    realtime t0, t1, t2;
    int hi;
    hi = 0;
    repeat (4) @(posedge sys_clk);
    t0 = $realtime; @(posedge sys_clk);
    t1 = $realtime; @(posedge sys_clk);
    t2 = $realtime;
    chk(req, "sys period a", int'((t1 - t0) * 1000.0), exp_ps);
    chk(req, "sys period b", int'((t2 - t1) * 1000.0), exp_ps);
    for (int k = 0; k < 9; k++) begin
      @(negedge sys_clk);
      if (inst_en) hi++;
    end
    chk("R7", "inst pulses in 9 cycles", hi, 3);
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk_ring); mode = m;
    repeat (30) @(posedge clk_ring);
  endtask

  task automatic strobe(input bit c, input bit r);
    @(negedge clk_ring); cer = c; rc = r;
    @(negedge clk_ring); cer = 0; rc = 0;
  endtask

  initial begin
    logic [2:0] dir [4];
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h1f2e3d);
    dir[0] = 3'b000; dir[1] = 3'b011; dir[2] = 3'b100; dir[3] = 3'b111;

    do_reset();
    wake_test(1'b1);
    wake_test(1'b0);
    // R1: sub bit ignored without latched type; ring divided
    set_mode(3'b001);
    chk("R1", "src with sub bit unlatched", int'(src), 0);
    measure("R1", RING_PS);
    set_mode(3'b110);
    chk("R5", "src ring div8", int'(src), 0);
    measure("R5", exp_period(3'b110, 1'b0));

    for (int t = 0; t < 6; t++) begin
      int choice, main_code;
      do_reset();
      choice = (t < 3) ? t : int'($urandom % 3);
      strobe(choice != 1, choice != 0);
      main_code = (choice == 1) ? 2 : 1;
      chk("R2", "src after strobe", int'(src), main_code);
      strobe(choice == 1, choice != 1);
      chk("R3", "src after second strobe", int'(src), main_code);
      strobe(1'b1, 1'b1);
      chk("R3", "src after both strobes", int'(src), main_code);
      for (int k = 0; k < 4; k++) begin
        logic [2:0] m;
        m = (t == 0 || t == 1) ? dir[k] : 3'($urandom % 8);
        set_mode(m);
        chk("R4", "src for mode", int'(src), exp_code(m, main_code));
        measure("R5", exp_period(m, 1'b1));
      end
      set_mode(3'b000);
      chk("R3", "src back on main", int'(src), main_code);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule